// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers asynchronous serial frames from one input line, such as the line behind an RS-232 level shifter that links a programmable-logic slave to a PC. A frame starts with a single low start bit. A fixed number of data bits follows, then one or more high stop bits. The receiver puts the line through a two-flop synchroniser. It arms on a high-to-low transition while idle, then samples every bit at the centre of its period. Bit timing comes from a 16x oversampling enable, which the block derives by dividing its own clock.

The data width, the stop-bit count and the arrival order of the data bits are compile-time parameters. Arrival order means whether the first data bit received lands in the most or the least significant position. Each completed frame gives a parallel word with a one-cycle valid strobe. A framing-error flag shares the strobe when any stop bit was sampled low. A busy flag shows that the control state machine is away from idle. It is high while the machine waits for an oversampling enable or takes a bit on one. The divider ratio is `CLK_HZ / (16 * BAUD)`. At the default 115200 bps, an 8-data, 1-stop frame takes ten bit periods, about 86.8 µs.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset `rx_busy`, `rx_valid` and `rx_frame_err` are low and `rx_data` is zero.
- R2: With `MSB_FIRST = 0`, the first data bit to arrive is placed in `rx_data[0]` and the last in `rx_data[DATA_BITS-1]`.
- R3: With `MSB_FIRST = 1`, the first data bit to arrive is placed in `rx_data[DATA_BITS-1]` and the last in `rx_data[0]`.
- R4: `rx_valid` is high for exactly one clock cycle per received frame. `rx_data` changes only in that cycle and holds its value until the next frame.
- R5: `rx_busy` is high from the detection of a start edge until the frame completes or is abandoned, and is low whenever `rx_valid` is high.
- R6: Frames sent back to back, with the next start bit following the last stop bit directly, are all received in order.
- R7: The bit period is 16 oversampling ticks of `CLK_HZ/(16*BAUD)` clocks each. For 8 data bits and 1 stop bit, `rx_valid` rises between 9 and 10 bit periods after the line falls at the start of a frame.
- R8: If the line is high again at the middle of the start bit, the block returns to idle and produces no `rx_valid`.
- R9: If any stop bit is sampled low, `rx_frame_err` is high in the same cycle as `rx_valid` and the data word is still delivered. `rx_frame_err` is never high without `rx_valid`, and is low for frames whose stop bits are all high.
- R10: With `STOP_BITS = 2`, a low second stop bit with a high first stop bit still raises `rx_frame_err`.
- R11: A new frame starts only on a high-to-low transition of the synchronised line. A line held low after a frame ends starts no frame and produces no `rx_valid` until it has gone high and low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | DATA_BITS | Last received data word |
| rx_valid | output | 1 | One-cycle strobe: a frame has completed |
| rx_frame_err | output | 1 | Stop-bit error for the frame strobed by `rx_valid` |
| rx_busy | output | 1 | Control state machine is not idle |

## Verification
The hardest situation to produce at the ports is a line that stays low after a frame has ended. That happens after a frame with a bad stop bit. An edge-less design would then take the held-low line for a new start bit and strobe out rubbish. The bench sends a frame whose stop bit is driven low and keeps the line low for several bit periods. It checks that no strobe appears and that busy stays low. It then lets the line rise and sends a clean frame to show that the block recovers. Start glitches shorter than half a bit and back-to-back frames in both bit orders, including a two-stop variant whose second stop bit alone is bad, cover the other paths through the state machine.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD      = 115_200,
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 1,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_frame_err,
  output logic                 rx_busy
);

  localparam int OS_RAW = CLK_HZ / (BAUD * 16);
  localparam int OS_DIV = (OS_RAW < 1) ? 1 : OS_RAW;
  localparam int DIV_W  = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;
  localparam int TOTAL  = DATA_BITS + STOP_BITS;
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OS_DIV - 1);
  localparam logic [3:0] HALF_BIT = 4'd7;
  localparam logic [3:0] FULL_BIT = 4'd15;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} state_t;

  state_t               state;
  logic                 sync1, rx_s, rx_prev;
  logic [DIV_W-1:0]     div_cnt;
  logic [3:0]           os_cnt;
  logic                 in_start, ferr_acc;
  logic [CNT_W-1:0]     bit_cnt;
  logic [DATA_BITS-1:0] shreg, shifted;
  logic                 tick, fall;

  assign tick    = (div_cnt == DIV_LAST);
  assign fall    = rx_prev & ~rx_s;
  assign rx_busy = (state != S_IDLE);

  generate
    if (MSB_FIRST) begin : g_msb
      assign shifted = {shreg[DATA_BITS-2:0], rx_s};
    end else begin : g_lsb
      assign shifted = {rx_s, shreg[DATA_BITS-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b1;
      rx_s    <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      sync1   <= rx_line;
      rx_s    <= sync1;
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      div_cnt <= '0;
    else if (state == S_IDLE && fall) div_cnt <= '0;
    else if (tick)                   div_cnt <= '0;
    else                             div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      os_cnt       <= HALF_BIT;
      in_start     <= 1'b1;
      ferr_acc     <= 1'b0;
      bit_cnt      <= CNT_W'(TOTAL);
      shreg        <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      case (state)
        S_IDLE: begin
          bit_cnt  <= CNT_W'(TOTAL);
          ferr_acc <= 1'b0;
          in_start <= 1'b1;
          os_cnt   <= HALF_BIT;
          if (fall) state <= S_WAIT;
        end
        S_WAIT: begin
          if (tick) begin
            if (os_cnt == 4'd0) state <= S_SHIFT;
            else                os_cnt <= os_cnt - 4'd1;
          end
        end
        S_SHIFT: begin
          os_cnt <= FULL_BIT;
          if (in_start) begin
            if (rx_s) begin
              state <= S_IDLE;
            end else begin
              in_start <= 1'b0;
              state    <= S_WAIT;
            end
          end else begin
            bit_cnt <= bit_cnt - 1'b1;
            if (bit_cnt > CNT_W'(STOP_BITS)) shreg <= shifted;
            else if (!rx_s)                  ferr_acc <= 1'b1;
            if (bit_cnt == CNT_W'(1)) begin
              state        <= S_IDLE;
              rx_valid     <= 1'b1;
              rx_data      <= shreg;
              rx_frame_err <= ferr_acc | ~rx_s;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_err_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> rx_valid);

  assert_valid_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rx_busy);

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid);

  assert_busy_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> $past(fall));

  assert_valid_after_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(state) == S_SHIFT);

endmodule

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;

  localparam int BIT = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx0 = 1'b1, rx1 = 1'b1;
  logic [7:0] d0, d1;
  logic v0, v1, e0, e1, b0, b1;

  always #5 clk = ~clk;

  serial_frame_rx #(.CLK_HZ(100_000_000), .BAUD(1_562_500), .DATA_BITS(8),
                    .STOP_BITS(1), .MSB_FIRST(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx0), .rx_data(d0),
    .rx_valid(v0), .rx_frame_err(e0), .rx_busy(b0));

  serial_frame_rx #(.CLK_HZ(100_000_000), .BAUD(1_562_500), .DATA_BITS(8),
                    .STOP_BITS(2), .MSB_FIRST(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx1), .rx_data(d1),
    .rx_valid(v1), .rx_frame_err(e1), .rx_busy(b1));

  int checks = 0, fails = 0, cyc = 0;
  int cnt0 = 0, cnt1 = 0;
  int t_start0 = 0, t_valid0 = 0;
  logic [7:0] log0 [0:15];
  logic [7:0] log1 [0:15];
  logic err0 [0:15];
  logic err1 [0:15];
  int width_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (v0) begin
      if (cnt0 < 16) begin log0[cnt0] = d0; err0[cnt0] = e0; end
      cnt0 = cnt0 + 1;
      t_valid0 = cyc;
    end
    if (v1) begin
      if (cnt1 < 16) begin log1[cnt1] = d1; err1[cnt1] = e1; end
      cnt1 = cnt1 + 1;
    end
  end

  logic v0_q = 1'b0;
  always @(negedge clk) begin
    if (v0 && v0_q) width_bad = width_bad + 1;
    v0_q = v0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input int which, input logic b);
    if (which == 0) rx0 = b; else rx1 = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send(input int which, input logic [7:0] w, input bit bad1, input bit bad2);
    if (which == 0) t_start0 = cyc;
    drive_bit(which, 1'b0);
    for (int i = 0; i < 8; i++)
      drive_bit(which, (which == 0) ? w[i] : w[7-i]);
    drive_bit(which, ~bad1);
    if (which == 1) drive_bit(which, ~bad2);
  endtask

  task automatic t_reset;
    check(b0 == 0 && b1 == 0, "R1 busy", {b1, b0}, 0);
    check(cnt0 == 0 && cnt1 == 0, "R1 valid", cnt0 + cnt1, 0);
    check(d0 == 0 && d1 == 0 && e0 == 0 && e1 == 0, "R1 data", {d1, d0}, 0);
  endtask

  task automatic t_lsb_back_to_back;
    int base;
    base = cnt0;
    send(0, 8'hA5, 0, 0);
    send(0, 8'h3C, 0, 0);
    send(0, 8'h01, 0, 0);
    rx0 = 1'b1;
    repeat (BIT) @(negedge clk);
    check(cnt0 == base + 3, "R6 frame count lsb", cnt0 - base, 3);
    check(log0[base] == 8'hA5, "R2 word0", log0[base], 8'hA5);
    check(log0[base+1] == 8'h3C, "R2 word1", log0[base+1], 8'h3C);
    check(log0[base+2] == 8'h01, "R2 word2", log0[base+2], 8'h01);
    check(err0[base] == 0 && err0[base+1] == 0, "R9 no err on good", err0[base], 0);
    check(width_bad == 0, "R4 strobe width", width_bad, 0);
    check(d0 == 8'h01, "R4 data held", d0, 8'h01);
    check(b0 == 0, "R5 idle after frames", b0, 0);
  endtask

  task automatic t_msb_two_stop;
    int base;
    base = cnt1;
    send(1, 8'hA5, 0, 0);
    send(1, 8'h80, 0, 0);
    rx1 = 1'b1;
    repeat (BIT) @(negedge clk);
    check(cnt1 == base + 2, "R6 frame count msb", cnt1 - base, 2);
    check(log1[base] == 8'hA5, "R3 word0", log1[base], 8'hA5);
    check(log1[base+1] == 8'h80, "R3 word1", log1[base+1], 8'h80);
    check(err1[base] == 0, "R9 no err 2-stop", err1[base], 0);
  endtask

  task automatic t_timing_busy;
    int base;
    base = cnt0;
    fork
      send(0, 8'h5A, 0, 0);
      begin
        repeat (3 * BIT) @(negedge clk);
        check(b0 == 1, "R5 busy mid frame", b0, 1);
      end
    join
    rx0 = 1'b1;
    repeat (BIT) @(negedge clk);
    check(cnt0 == base + 1 && log0[base] == 8'h5A, "R7 frame data", log0[base], 8'h5A);
    check(t_valid0 - t_start0 >= 9 * BIT && t_valid0 - t_start0 <= 10 * BIT,
          "R7 valid latency", t_valid0 - t_start0, 9 * BIT + BIT / 2);
  endtask

  task automatic t_glitch;
    int base;
    base = cnt0;
    rx0 = 1'b0;
    repeat (16) @(negedge clk);
    rx0 = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    check(cnt0 == base, "R8 glitch no output", cnt0 - base, 0);
    check(b0 == 0, "R8 glitch back to idle", b0, 0);
  endtask

  task automatic t_frame_err_and_held_low;
    int base;
    base = cnt0;
    send(0, 8'hC3, 1, 0);
    repeat (4 * BIT) @(negedge clk);
    check(cnt0 == base + 1, "R9 err frame delivered", cnt0 - base, 1);
    check(err0[base] == 1 && log0[base] == 8'hC3, "R9 err flag and data", {err0[base], log0[base]}, 9'h1C3);
    check(b0 == 0, "R11 held low stays idle", b0, 0);
    rx0 = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check(cnt0 == base + 1, "R11 no frame from held low", cnt0 - base, 1);
    send(0, 8'h7E, 0, 0);
    rx0 = 1'b1;
    repeat (BIT) @(negedge clk);
    check(cnt0 == base + 2 && log0[base+1] == 8'h7E && err0[base+1] == 0,
          "R11 recovery frame", log0[base+1], 8'h7E);
  endtask

  task automatic t_second_stop_bad;
    int base;
    base = cnt1;
    send(1, 8'h96, 0, 1);
    rx1 = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check(cnt1 == base + 1, "R10 frame delivered", cnt1 - base, 1);
    check(err1[base] == 1 && log1[base] == 8'h96, "R10 second stop err", {err1[base], log1[base]}, 9'h196);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_lsb_back_to_back();
    t_msb_two_stop();
    t_timing_busy();
    t_glitch();
    t_frame_err_and_held_low();
    t_second_stop_bad();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule